// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block is a clock-master stereo serial audio port with one transmit lane and one receive lane. From its own clock it derives a bit clock and a word-select clock through two cascaded divider stages. Each bit slot lasts `div_a * div_b` clocks, and each frame holds 32 slots, so the frame rate is the base clock divided by 32, then by `div_a`, then by `div_b`. A frame carries two 16-bit channels. Each channel goes out MSB first, and its MSB follows the word-select edge by one slot, which is the usual I2S alignment.

On the parallel side each direction moves 32-bit words with valid/ready handshakes. A word holds the left channel in bits 15:0 and the right channel in bits 31:16. The transmit side has a one-word holding register, which is drained at each frame boundary. The receive side delivers one word per frame. It does this only while a programmed word budget remains, and the budget is reloaded by an arm pulse. Sticky flags report transmit underflow and receive overflow. A synchronous soft reset clears both lanes.

Top module: `stereo_serial_port`

## Requirements
- R1: A bit slot lasts A*B clock cycles, where A and B are `div_a_i` and `div_b_i`, and a divider value of 0 acts as 1. A frame is 32 slots, so word select has a period of 32*A*B cycles.
- R2: Divider values and `right_first_i` take effect only at the end of slot 31 of a frame, or during soft reset. A frame in progress keeps its old slot length.
- R3: `ws_o` is 0 while the left channel is on the line and 1 while the right channel is. It changes one slot before each channel's MSB, at the starts of slots 15 and 31. Slots 0-15 carry the first channel and slots 16-31 carry the second, each MSB first. `sd_o` and `ws_o` change only at slot starts.
- R4: A word maps left to bits 15:0 and right to bits 31:16. When `right_first_i` is 1 the right channel takes slots 0-15, and when it is 0 the left channel does. A word sent in loopback is received unchanged under either order.
- R5: `tx_ready_o` is 1 when the one-word holding register is empty. A word is accepted when `tx_valid_i` and `tx_ready_o` are both 1. While `tx_en_i` is 1, the held word moves to the line at the next frame boundary.
- R6: If `tx_en_i` is 1 and the holding register is empty at a frame boundary, the next frame sends zeros and `tx_underflow_o` sets and stays set until soft reset.
- R7: `sd_i` is sampled in the last clock of every slot. At the end of slot 31 the 32 sampled bits are repacked per R4 and presented on `rx_data_o` with `rx_valid_o`. Both are held until `rx_ready_i`.
- R8: A frame is captured only while `rx_en_i` is 1 and the word budget is non-zero. Each capture, including a dropped one, uses up one unit of budget. `rx_arm_i` loads the budget from `rx_count_i`, and `rx_busy_o` is 1 while budget remains.
- R9: A capture that happens while an unread word is still held is dropped, the held word is kept, and `rx_overflow_o` sets and stays set until soft reset.
- R10: While `soft_rst_i` is 1, the holding registers, shift registers, flags, budget and slot counters clear and the divider settings load. After a soft reset `tx_ready_o`=1 and `rx_valid_o`=0.
- R11: `sck_o` is 0 for the first floor(A*B/2) clocks of each slot and 1 for the rest.
- R12: With `tx_en_i` at 0, frames send zeros, no underflow is flagged, and a held word stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of both lanes |
| tx_en_i | input | 1 | Transmit enable |
| rx_en_i | input | 1 | Receive enable |
| right_first_i | input | 1 | Right channel occupies the first half of the frame |
| div_a_i | input | DIV_W | First divider stage |
| div_b_i | input | DIV_W | Second divider stage |
| tx_data_i | input | 32 | Transmit word {right, left} |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Holding register empty |
| rx_arm_i | input | 1 | Load receive budget |
| rx_count_i | input | RXCNT_W | Receive budget in words |
| rx_data_o | output | 32 | Received word {right, left} |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Receive word taken |
| rx_busy_o | output | 1 | Receive budget non-zero |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |
| tx_underflow_o | output | 1 | Sticky transmit underflow |
| rx_overflow_o | output | 1 | Sticky receive overflow |

## Verification
A slot counter or divider stage in the wrong state moves `ws_o` and `sck_o` edges away from their expected positions within one slot. The cycle-accurate comparison therefore flags it at the first wrong clock. A bad holding or shift register shows up in a loopback word that differs in one channel or has its channels swapped, and this appears at the next frame end. A flag or budget error shows at the ports as a sticky flag, busy line or valid line that disagrees with the model, starting in the cycle after the frame boundary that caused it.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam int CH_W   = 16;
  localparam int WORD_W = 2 * CH_W;
  localparam int SLOT_W = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] SLOT_LAST   = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] WS_SET_SLOT = SLOT_W'(CH_W - 1);
  localparam logic [SLOT_W-1:0] WS_CLR_SLOT = SLOT_W'(WORD_W - 2);

  // Swap halves unless right channel goes first; self-inverse.
  function automatic logic [WORD_W-1:0] line_order(input logic [WORD_W-1:0] w,
                                                   input logic rf);
    return rf ? w : {w[CH_W-1:0], w[WORD_W-1:CH_W]};
  endfunction
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen
  import ssp_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [DIV_W-1:0]  div_a_i,
  input  logic [DIV_W-1:0]  div_b_i,
  input  logic              right_first_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_end_o,
  output logic              frame_end_o,
  output logic              rf_o,
  output logic              sck_o,
  output logic              ws_o
);
  localparam int PROD_W = 2 * DIV_W;

  logic [DIV_W-1:0]  a_q, b_q, ca_q, cb_q, a_eff, b_eff;
  logic [PROD_W-1:0] pc_q, slot_len, half_len;
  logic [SLOT_W-1:0] slot_q;
  logic              rf_q, a_wrap, slot_end, frame_end, second_half;

  assign a_eff     = (div_a_i == '0) ? DIV_W'(1) : div_a_i;
  assign b_eff     = (div_b_i == '0) ? DIV_W'(1) : div_b_i;
  assign slot_len  = PROD_W'(a_q) * PROD_W'(b_q);
  assign half_len  = slot_len >> 1;
  assign a_wrap    = (ca_q == a_q - DIV_W'(1));
  assign slot_end  = a_wrap && (cb_q == b_q - DIV_W'(1));
  assign frame_end = slot_end && (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= DIV_W'(1);
      b_q    <= DIV_W'(1);
      ca_q   <= '0;
      cb_q   <= '0;
      pc_q   <= '0;
      slot_q <= '0;
      rf_q   <= 1'b0;
    end else if (soft_rst_i) begin
      a_q    <= a_eff;
      b_q    <= b_eff;
      ca_q   <= '0;
      cb_q   <= '0;
      pc_q   <= '0;
      slot_q <= '0;
      rf_q   <= right_first_i;
    end else begin
      ca_q <= a_wrap ? '0 : ca_q + DIV_W'(1);
      if (slot_end) begin
        cb_q   <= '0;
        pc_q   <= '0;
        slot_q <= slot_q + SLOT_W'(1);
      end else begin
        if (a_wrap) cb_q <= cb_q + DIV_W'(1);
        pc_q <= pc_q + PROD_W'(1);
      end
      // settings only change between frames
      if (frame_end) begin
        a_q  <= a_eff;
        b_q  <= b_eff;
        rf_q <= right_first_i;
      end
    end
  end

  assign second_half = (slot_q >= WS_SET_SLOT) && (slot_q <= WS_CLR_SLOT);
  assign ws_o        = second_half ^ rf_q;
  assign sck_o       = (pc_q >= half_len);
  assign slot_o      = slot_q;
  assign slot_end_o  = slot_end;
  assign frame_end_o = frame_end;
  assign rf_o        = rf_q;
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx
  import ssp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              en_i,
  input  logic              frame_end_i,
  input  logic              right_first_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sd_o,
  output logic              underflow_o
);
  logic [WORD_W-1:0] hold_q, sh_q;
  logic              full_q, und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      und_q  <= 1'b0;
    end else if (soft_rst_i) begin
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      if (frame_end_i) begin
        if (en_i && full_q) begin
          sh_q   <= line_order(hold_q, right_first_i);
          full_q <= 1'b0;
        end else begin
          sh_q <= '0;
          if (en_i) und_q <= 1'b1;
        end
      end
      if (valid_i && !full_q) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end
    end
  end

  // slot k carries line bit 31-k, i.e. index ~k
  assign sd_o        = sh_q[~slot_i];
  assign ready_o     = !full_q;
  assign underflow_o = und_q;
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              en_i,
  input  logic              arm_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              slot_end_i,
  input  logic              frame_end_i,
  input  logic              rf_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              overflow_o
);
  logic [WORD_W-1:0] sh_q, data_q, frame_word;
  logic [CNT_W-1:0]  rem_q;
  logic              valid_q, ovf_q, capture;

  assign frame_word = {sh_q[WORD_W-2:0], sd_i};
  assign capture    = frame_end_i && en_i && (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (soft_rst_i) begin
      sh_q    <= '0;
      data_q  <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (slot_end_i) sh_q <= frame_word;
      if (valid_q && ready_i) valid_q <= 1'b0;
      if (capture) begin
        rem_q <= rem_q - CNT_W'(1);
        if (valid_q && !ready_i) begin
          ovf_q <= 1'b1;
        end else begin
          data_q  <= line_order(frame_word, rf_i);
          valid_q <= 1'b1;
        end
      end
      if (arm_i) rem_q <= count_i;
    end
  end

  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign busy_o     = (rem_q != '0);
  assign overflow_o = ovf_q;
endmodule

// File: rtl/stereo_serial_port.sv
`timescale 1ns/1ps
module stereo_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int RXCNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic               right_first_i,
  input  logic [DIV_W-1:0]   div_a_i,
  input  logic [DIV_W-1:0]   div_b_i,
  input  logic [31:0]        tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic               rx_arm_i,
  input  logic [RXCNT_W-1:0] rx_count_i,
  output logic [31:0]        rx_data_o,
  output logic               rx_valid_o,
  input  logic               rx_ready_i,
  output logic               rx_busy_o,
  output logic               sck_o,
  output logic               ws_o,
  output logic               sd_o,
  input  logic               sd_i,
  output logic               tx_underflow_o,
  output logic               rx_overflow_o
);
  logic [SLOT_W-1:0] slot;
  logic              slot_end, frame_end, rf_q;

  ssp_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .div_a_i       (div_a_i),
    .div_b_i       (div_b_i),
    .right_first_i (right_first_i),
    .slot_o        (slot),
    .slot_end_o    (slot_end),
    .frame_end_o   (frame_end),
    .rf_o          (rf_q),
    .sck_o         (sck_o),
    .ws_o          (ws_o)
  );

  ssp_tx u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .en_i          (tx_en_i),
    .frame_end_i   (frame_end),
    .right_first_i (right_first_i),
    .slot_i        (slot),
    .data_i        (tx_data_i),
    .valid_i       (tx_valid_i),
    .ready_o       (tx_ready_o),
    .sd_o          (sd_o),
    .underflow_o   (tx_underflow_o)
  );

  ssp_rx #(.CNT_W(RXCNT_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .en_i        (rx_en_i),
    .arm_i       (rx_arm_i),
    .count_i     (rx_count_i),
    .slot_end_i  (slot_end),
    .frame_end_i (frame_end),
    .rf_i        (rf_q),
    .sd_i        (sd_i),
    .data_o      (rx_data_o),
    .valid_o     (rx_valid_o),
    .ready_i     (rx_ready_i),
    .busy_o      (rx_busy_o),
    .overflow_o  (rx_overflow_o)
  );
endmodule

// File: rtl/ssp_chk.sv
`timescale 1ns/1ps
module ssp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        soft_rst_i,
  input logic        slot_end_i,
  input logic        sd_i,
  input logic        ws_i,
  input logic        tx_valid_i,
  input logic        tx_ready_i,
  input logic        rx_valid_i,
  input logic        rx_ready_i,
  input logic [31:0] rx_data_i,
  input logic        rx_arm_i,
  input logic        rx_busy_i,
  input logic        und_i,
  input logic        ovf_i
);
  // R3
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i && !soft_rst_i |=> $stable(sd_i) && $stable(ws_i));
  // R5
  tx_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_i && !soft_rst_i |=> !tx_ready_i);
  // R6
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_i && !soft_rst_i |=> und_i);
  // R7
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !rx_ready_i && !soft_rst_i |=> rx_valid_i && $stable(rx_data_i));
  // R8
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_busy_i && !rx_arm_i && !soft_rst_i |=> !rx_busy_i);
  // R9
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i && !soft_rst_i |=> ovf_i);
  // R10
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !und_i && !ovf_i && !rx_valid_i && tx_ready_i && !rx_busy_i);
endmodule

bind stereo_serial_port ssp_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .slot_end_i (slot_end),
  .sd_i       (sd_o),
  .ws_i       (ws_o),
  .tx_valid_i (tx_valid_i),
  .tx_ready_i (tx_ready_o),
  .rx_valid_i (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_data_i  (rx_data_o),
  .rx_arm_i   (rx_arm_i),
  .rx_busy_i  (rx_busy_o),
  .und_i      (tx_underflow_o),
  .ovf_i      (rx_overflow_o)
);

// File: tb/stereo_serial_port_tb_top.sv
`timescale 1ns/1ps
module stereo_serial_port_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0, soft_rst_i = 1'b0;
  logic        tx_en_i = 1'b0, rx_en_i = 1'b0, right_first_i = 1'b0;
  logic [5:0]  div_a_i = 6'd1, div_b_i = 6'd1;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0, rx_arm_i = 1'b0, rx_ready_i = 1'b1;
  logic [15:0] rx_count_i = '0;
  logic        tx_ready_o, rx_valid_o, rx_busy_o, sck_o, ws_o, sd_o;
  logic        tx_underflow_o, rx_overflow_o;
  logic [31:0] rx_data_o;

  int checks = 0, failures = 0;
  bit done = 0, seen_sd = 0;
  logic [31:0] got[$];

  always #2 clk_i = ~clk_i;

  stereo_serial_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .tx_en_i(tx_en_i), .rx_en_i(rx_en_i), .right_first_i(right_first_i),
    .div_a_i(div_a_i), .div_b_i(div_b_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_arm_i(rx_arm_i), .rx_count_i(rx_count_i), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_busy_o(rx_busy_o),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .sd_i(sd_o),
    .tx_underflow_o(tx_underflow_o), .rx_overflow_o(rx_overflow_o)
  );

  // ---------------- reference model ----------------
  int m_a, m_b, m_phase, m_slot, m_rem;
  logic m_rf, m_full, m_und, m_val, m_ovf;
  logic [31:0] m_hold, m_sh, m_rxsh, m_data;

  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction
  function automatic int eff(input logic [5:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic model_clear();
    m_phase = 0; m_slot = 0; m_rem = 0;
    m_full = 0; m_und = 0; m_val = 0; m_ovf = 0;
    m_hold = 0; m_sh = 0; m_rxsh = 0; m_data = 0;
  endtask

  task automatic model_step();
    int p;
    bit last, fe, orig_v, orig_full, cap;
    logic [31:0] fw;
    if (soft_rst_i) begin
      model_clear();
      m_a = eff(div_a_i); m_b = eff(div_b_i); m_rf = right_first_i;
      return;
    end
    p = m_a * m_b;
    last = (m_phase == p - 1);
    fe = last && (m_slot == 31);
    fw = {m_rxsh[30:0], m_sh[31 - m_slot]};
    orig_v = m_val;
    cap = fe && rx_en_i && (m_rem > 0);
    if (last) m_rxsh = fw;
    if (orig_v && rx_ready_i) m_val = 0;
    if (cap) begin
      m_rem--;
      if (orig_v && !rx_ready_i) m_ovf = 1;
      else begin m_data = m_rf ? fw : swp(fw); m_val = 1; end
    end
    if (rx_arm_i) m_rem = int'(rx_count_i);
    orig_full = m_full;
    if (fe) begin
      if (tx_en_i && orig_full) begin
        m_sh = right_first_i ? m_hold : swp(m_hold); m_full = 0;
      end else begin
        m_sh = 0; if (tx_en_i) m_und = 1;
      end
    end
    if (tx_valid_i && !orig_full) begin m_hold = tx_data_i; m_full = 1; end
    if (last) begin
      m_phase = 0; m_slot = (m_slot + 1) % 32;
      if (fe) begin m_a = eff(div_a_i); m_b = eff(div_b_i); m_rf = right_first_i; end
    end else m_phase++;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin model_clear(); m_a = 1; m_b = 1; m_rf = 0; end
    else model_step();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison and sampling, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R11 sck", sck_o, ((m_phase >= (m_a * m_b) / 2) ? 1 : 0));
      chk("R3 ws", ws_o, (((m_slot >= 15 && m_slot <= 30) ? 1'b1 : 1'b0) ^ m_rf));
      chk("R3 sd", sd_o, m_sh[31 - m_slot]);
      chk("R5 tx_ready", tx_ready_o, !m_full);
      chk("R6 underflow", tx_underflow_o, m_und);
      chk("R7 rx_valid", rx_valid_o, m_val);
      if (m_val) chk("R7 rx_data", rx_data_o, m_data);
      chk("R9 overflow", rx_overflow_o, m_ovf);
      chk("R8 busy", rx_busy_o, (m_rem > 0));
      if (rx_valid_o && rx_ready_i) got.push_back(rx_data_o);
      if (sd_o) seen_sd = 1;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick_in(); @(posedge clk_i); #1; endtask

  task automatic pulse_soft();
    soft_rst_i = 1; tick_in(); soft_rst_i = 0;
  endtask

  task automatic arm(input int n);
    rx_count_i = 16'(n); rx_arm_i = 1; tick_in(); rx_arm_i = 0;
  endtask

  task automatic send(input logic [31:0] w);
    while (!tx_ready_o) tick_in();
    tx_data_i = w; tx_valid_i = 1; tick_in(); tx_valid_i = 0;
  endtask

  task automatic wait_ws_rise();
    logic p;
    p = ws_o;
    forever begin
      @(negedge clk_i);
      if (ws_o && !p) break;
      p = ws_o;
    end
  endtask

  task automatic count_until(input logic v, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (ws_o !== v);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n1, n2;
    repeat (3) tick_in();
    rst_ni = 1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 reset tx_ready", tx_ready_o, 1);
    chk("R10 reset rx_valid", rx_valid_o, 0);
    chk("R10 reset flags", {tx_underflow_o, rx_overflow_o, rx_busy_o}, 0);
    chk("R10 reset ws", ws_o, 0);

    // Phase A: left-first loopback, slot of 2 clocks, budget of 3
    tick_in();
    div_a_i = 2; div_b_i = 1; tx_en_i = 1; rx_en_i = 1; right_first_i = 0;
    pulse_soft();
    arm(3);
    send(32'hA5C3_1234); send(32'h0F0F_8001); send(32'h7E11_C0DE); send(32'h1357_9BDF);
    while (rx_busy_o) tick_in();
    repeat (4) tick_in();
    chk("R8 capture count", got.size(), 3);
    if (got.size() == 3) begin
      chk("R7 first frame zero", got[0], 32'h0);
      chk("R4 loopback word0", got[1], 32'hA5C3_1234);
      chk("R4 loopback word1", got[2], 32'h0F0F_8001);
    end
    // R1 steady frame length at A*B=2
    wait_ws_rise(); count_until(0, n1); count_until(1, n2);
    chk("R1 half frame 2x1", n1, 32); chk("R1 frame 2x1", n1 + n2, 64);
    wait_ws_rise(); wait_ws_rise();
    chk("R6 underflow sticky", tx_underflow_o, 1);
    chk("R8 budget spent", rx_busy_o, 0);

    // Phase B: zero divider acts as one, then change mid-frame
    div_a_i = 0; div_b_i = 3;
    pulse_soft();
    chk("R10 soft clears underflow", tx_underflow_o, 0);
    wait_ws_rise(); count_until(0, n1); count_until(1, n2);
    chk("R1 zero div half", n1, 48); chk("R1 zero div frame", n1 + n2, 96);
    wait_ws_rise();
    div_a_i = 2; div_b_i = 2;
    count_until(0, n1); count_until(1, n2);
    chk("R2 old length holds", n1, 48);
    chk("R2 new length next frame", n2, 3 + 15 * 4);

    // right-first loopback
    right_first_i = 1;
    wait_ws_rise(); wait_ws_rise();
    got.delete();
    wait_ws_rise();
    arm(2);
    send(32'hBEEF_0042);
    while (rx_busy_o) tick_in();
    repeat (4) tick_in();
    chk("R8 count two", got.size(), 2);
    if (got.size() == 2) chk("R4 right-first loopback", got[1], 32'hBEEF_0042);

    // Phase C: overflow
    right_first_i = 0; div_a_i = 1; div_b_i = 2; rx_ready_i = 0;
    pulse_soft();
    got.delete();
    arm(3);
    send(32'h2222_1111);
    repeat (3) wait_ws_rise();
    chk("R9 overflow set", rx_overflow_o, 1);
    chk("R9 held valid", rx_valid_o, 1);
    chk("R9 held word kept", rx_data_o, 32'h0);
    tick_in(); rx_ready_i = 1;

    // Phase D: transmit disabled
    tx_en_i = 0;
    pulse_soft();
    chk("R10 soft clears overflow", rx_overflow_o, 0);
    chk("R10 soft clears valid", rx_valid_o, 0);
    send(32'hFFFF_FFFF);
    seen_sd = 0;
    repeat (3) wait_ws_rise();
    chk("R12 word still held", tx_ready_o, 0);
    chk("R12 no underflow", tx_underflow_o, 0);
    chk("R12 line zero", seen_sd, 0);
    tx_en_i = 1;
    repeat (2) wait_ws_rise();
    chk("R12 consumed after enable", tx_ready_o, 1);
    finish_run();
  end
endmodule